// File: doc/BRIEF.md
# DDR mode register load sequencer

This block sits between a host configuration port and the command bus of a DDR SDRAM. The host asks for a write of either the base mode register or the extended mode register by presenting a target select and a 13-bit value. The sequencer checks the value, waits until every bank is idle and no burst is running, drives the load command, and then holds the bus at NOP for a fixed settling time. When an extended load switches the DLL on, the sequencer follows it with a base mode register load. That second load reuses the last base value and has the DLL-reset bit set.

The block also decides when reads may go out. A DLL enable, whether from an extended load or from leaving self refresh, starts a lock timer. Read requests that arrive before the timer expires are counted and held. Once the DLL has locked, they are issued one per cycle. A request that would program a reserved or unsupported extended field is refused and flagged, and no command results.

Top module: `ddr_modeload_seq`

## Requirements
- R1: After reset the command output is NOP (2'b00), and `busy_o`, `rd_ok_o` and `err_o` are all low.
- R2: A load drives command 2'b01 with `addr_o` equal to the requested value. `ba_o` is 2'b01 (bit 0 high, bit 1 low) for the extended register and 2'b00 for the base register.
- R3: An extended request is refused if any of bits 2..12 is set, or if bit 1 (reduced drive) is set while `REDUCED_OK` is 0. A refused request raises `err_o` in the next cycle, produces no load and leaves `busy_o` low.
- R4: A load is issued only at a clock edge where `banks_idle` is 1 and `burst_active` is 0. Until then the bus shows NOP and `busy_o` is high.
- R5: After every load, at least `SETTLE_CYC` NOP cycles follow before any other command. `busy_o` stays high through the settling time.
- R6: After an extended load with bit 0 = 0 (DLL on), the next command is a base load with address bit 8 (DLL reset) set.
- R7: The chained base load carries the value of the most recent base load requested by the host, with bit 8 forced to 1.
- R8: `rd_ok_o` rises exactly `LOCK_CYC` cycles after the cycle in which a DLL-enabling extended load appears. No READ (2'b10) is issued while `rd_ok_o` was low in the cycle before.
- R9: A pulse on `sr_exit` drops `rd_ok_o` in the next cycle, restarts the lock timer, and `rd_ok_o` returns `LOCK_CYC` cycles later.
- R10: An extended load with bit 0 = 1 (DLL off) clears `rd_ok_o`. It stays low, and held reads stay unissued, until the DLL is enabled again.
- R11: Read requests made while reads are not allowed are kept, not dropped. Each one later becomes exactly one READ command, issued one per cycle while the sequencer is idle.
- R12: If a held read is granted in the same cycle that a configuration request is accepted, the READ goes out first and the load follows after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_valid | input | 1 | Configuration request; taken when `busy_o` is low |
| cfg_ext | input | 1 | 1 = extended register, 0 = base register |
| cfg_value | input | AW | Register value to load |
| banks_idle | input | 1 | All banks idle |
| burst_active | input | 1 | A burst is in progress |
| rd_req | input | 1 | One read request per high cycle |
| sr_exit | input | 1 | Self-refresh exit pulse |
| cmd_o | output | 2 | Command: 00 NOP, 01 load mode register, 10 READ |
| ba_o | output | 2 | Bank address; bit 0 is BA0 |
| addr_o | output | AW | Address bus |
| busy_o | output | 1 | A load is pending, being issued or settling |
| rd_ok_o | output | 1 | DLL locked; reads may be issued |
| err_o | output | 1 | The previous cycle's request was refused |

## Verification
Two functions can land in the same cycle: granting a held read and accepting a new configuration request, since both are only allowed while the sequencer is idle. The bench sets this up by raising one read request one cycle ahead, then presenting a base load in the cycle when that read becomes grantable. It then expects a READ with `busy_o` already high, followed immediately by the load. The scoreboard judges the order, and the settling-gap and lock-window monitors confirm that neither rule was broken by the collision.

// File: rtl/ddr_modeload_pkg.sv
// Shared encodings for the mode register load sequencer.
// Assumes a command bus reduced to NOP, load-mode and READ.
package ddr_modeload_pkg;

    typedef enum logic [1:0] {
        CMD_NOP  = 2'b00,
        CMD_LMR  = 2'b01,
        CMD_READ = 2'b10
    } cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'b00,
        ST_WAIT   = 2'b01,
        ST_SETTLE = 2'b10
    } seq_st_e;

    localparam logic [1:0] BA_BASE = 2'b00;
    localparam logic [1:0] BA_EXT  = 2'b01;

    localparam int EXT_DLL_BIT = 0;
    localparam int EXT_DRV_BIT = 1;
    localparam int DLL_RST_BIT = 8;

endpackage

// File: rtl/ddr_modeload_vet.sv
// Legality screen for a configuration request.
// Extended values must keep bits 2 and up at zero; reduced drive (bit 1)
// is allowed only when REDUCED_OK is set. Base values are always legal.
module ddr_modeload_vet #(
    parameter int AW         = 13,
    parameter bit REDUCED_OK = 1'b0
) (
    input  logic          is_ext,
    input  logic [AW-1:0] value,
    output logic          legal
);
    import ddr_modeload_pkg::*;

    logic rsv_set;
    logic drv_bad;

    // Decide whether the requested value may be programmed.
    always_comb begin
        rsv_set = |value[AW-1:EXT_DRV_BIT+1];
        drv_bad = value[EXT_DRV_BIT] && !REDUCED_OK;
        legal   = !is_ext || !(rsv_set || drv_bad);
    end

endmodule

// File: rtl/ddr_modeload_lock.sv
// DLL lock tracker. A start event (DLL enable or self-refresh exit)
// reloads a countdown of LOCK_CYC; ready rises when it reaches zero.
// A stop event (DLL disable) wins over a start in the same cycle.
module ddr_modeload_lock #(
    parameter int LOCK_CYC = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic stop,
    output logic ready
);
    localparam int CW = $clog2(LOCK_CYC + 1);

    logic          dll_on;
    logic [CW-1:0] cnt;

    // Track DLL state and count down the lock window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dll_on <= 1'b0;
            cnt    <= '0;
        end else if (stop) begin
            dll_on <= 1'b0;
            cnt    <= '0;
        end else if (start) begin
            dll_on <= 1'b1;
            cnt    <= CW'(LOCK_CYC);
        end else if (cnt != '0) begin
            cnt    <= cnt - CW'(1);
        end
    end

    // Reads are allowed once the DLL is on and the window has run out.
    always_comb ready = dll_on && (cnt == '0);

endmodule

// File: rtl/ddr_modeload_rdhold.sv
// Holding counter for read requests. Requests are all alike, so a count
// preserves order; one grant removes one request. Assumes the host keeps
// no more than DEPTH requests outstanding; extra requests are not counted.
module ddr_modeload_rdhold #(
    parameter int DEPTH = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic grant,
    output logic pending
);
    localparam int CW = $clog2(DEPTH + 1);

    logic [CW-1:0] cnt;
    logic          full;

    always_comb full = (cnt == CW'(DEPTH));

    // Add incoming requests and remove granted ones.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else begin
            case ({req && (!full || grant), grant})
                2'b10:   cnt <= cnt + CW'(1);
                2'b01:   cnt <= cnt - CW'(1);
                default: cnt <= cnt;
            endcase
        end
    end

    always_comb pending = (cnt != '0);

endmodule

// File: rtl/ddr_modeload_seq.sv
// Mode register load sequencer (top).
// Takes one configuration request at a time while idle, waits for
// banks idle and no burst, drives the load, then settles for SETTLE_CYC
// NOP cycles. A DLL-enabling extended load is followed automatically by
// a base load of the shadowed value with the DLL-reset bit set. Held
// reads are issued only while idle and after the DLL has locked.
// Assumes SETTLE_CYC >= 1 and LOCK_CYC >= 1.
module ddr_modeload_seq #(
    parameter int          AW         = 13,
    parameter int          SETTLE_CYC = 2,
    parameter int          LOCK_CYC   = 200,
    parameter int          RD_DEPTH   = 8,
    parameter bit          REDUCED_OK = 1'b0,
    parameter logic [12:0] BASE_RST   = 13'h000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_valid,
    input  logic          cfg_ext,
    input  logic [AW-1:0] cfg_value,
    input  logic          banks_idle,
    input  logic          burst_active,
    input  logic          rd_req,
    input  logic          sr_exit,
    output logic [1:0]    cmd_o,
    output logic [1:0]    ba_o,
    output logic [AW-1:0] addr_o,
    output logic          busy_o,
    output logic          rd_ok_o,
    output logic          err_o
);
    import ddr_modeload_pkg::*;

    localparam int            SW       = $clog2(SETTLE_CYC + 1);
    localparam logic [AW-1:0] RST_MASK = {{(AW-1){1'b0}}, 1'b1} << DLL_RST_BIT;

    seq_st_e       st;
    cmd_e          cmd_q;
    logic [1:0]    ba_q;
    logic [AW-1:0] addr_q;
    logic          err_q;
    logic          pend_ext;
    logic [AW-1:0] pend_val;
    logic [AW-1:0] shadow;
    logic          chain;
    logic [SW-1:0] settle_cnt;

    logic cfg_legal;
    logic issue_lmr;
    logic dll_start;
    logic dll_stop;
    logic rd_ready;
    logic rd_pending;
    logic rd_go;

    ddr_modeload_vet #(
        .AW         (AW),
        .REDUCED_OK (REDUCED_OK)
    ) vet_i (
        .is_ext (cfg_ext),
        .value  (cfg_value),
        .legal  (cfg_legal)
    );

    // Decide the events of this cycle: load issue, DLL changes, read grant.
    always_comb begin
        issue_lmr = (st == ST_WAIT) && banks_idle && !burst_active;
        dll_start = (issue_lmr && pend_ext && !pend_val[EXT_DLL_BIT]) || sr_exit;
        dll_stop  = issue_lmr && pend_ext && pend_val[EXT_DLL_BIT];
        rd_go     = (st == ST_IDLE) && rd_ready && rd_pending;
    end

    ddr_modeload_lock #(
        .LOCK_CYC (LOCK_CYC)
    ) lock_i (
        .clk   (clk),
        .rst_n (rst_n),
        .start (dll_start),
        .stop  (dll_stop),
        .ready (rd_ready)
    );

    ddr_modeload_rdhold #(
        .DEPTH (RD_DEPTH)
    ) rdhold_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (rd_req),
        .grant   (rd_go),
        .pending (rd_pending)
    );

    // Sequence requests, drive the command bus and keep the base shadow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= ST_IDLE;
            cmd_q      <= CMD_NOP;
            ba_q       <= '0;
            addr_q     <= '0;
            err_q      <= 1'b0;
            pend_ext   <= 1'b0;
            pend_val   <= '0;
            shadow     <= AW'(BASE_RST);
            chain      <= 1'b0;
            settle_cnt <= '0;
        end else begin
            cmd_q  <= rd_go ? CMD_READ : CMD_NOP;
            ba_q   <= '0;
            addr_q <= '0;
            err_q  <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (cfg_valid) begin
                        if (cfg_legal) begin
                            pend_ext <= cfg_ext;
                            pend_val <= cfg_value;
                            st       <= ST_WAIT;
                        end else begin
                            err_q <= 1'b1;
                        end
                    end
                end
                ST_WAIT: begin
                    if (issue_lmr) begin
                        cmd_q      <= CMD_LMR;
                        ba_q       <= pend_ext ? BA_EXT : BA_BASE;
                        addr_q     <= pend_val;
                        settle_cnt <= SW'(SETTLE_CYC);
                        st         <= ST_SETTLE;
                        if (pend_ext) begin
                            chain <= !pend_val[EXT_DLL_BIT];
                        end else begin
                            shadow <= pend_val;
                            chain  <= 1'b0;
                        end
                    end
                end
                ST_SETTLE: begin
                    settle_cnt <= settle_cnt - SW'(1);
                    if (settle_cnt == SW'(1)) begin
                        if (chain) begin
                            pend_ext <= 1'b0;
                            pend_val <= shadow | RST_MASK;
                            chain    <= 1'b0;
                            st       <= ST_WAIT;
                        end else begin
                            st <= ST_IDLE;
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Present registered state on the ports.
    always_comb begin
        cmd_o   = cmd_q;
        ba_o    = ba_q;
        addr_o  = addr_q;
        err_o   = err_q;
        busy_o  = (st != ST_IDLE);
        rd_ok_o = rd_ready;
    end

endmodule

// File: rtl/ddr_modeload_seq_chk.sv
// Protocol checker for the mode register load sequencer, bound to the top.
// Observes only the top-level ports.
module ddr_modeload_seq_chk #(
    parameter int AW = 13
) (
    input logic          clk,
    input logic          rst_n,
    input logic          banks_idle,
    input logic          burst_active,
    input logic          sr_exit,
    input logic [1:0]    cmd_o,
    input logic [1:0]    ba_o,
    input logic [AW-1:0] addr_o,
    input logic          busy_o,
    input logic          rd_ok_o,
    input logic          err_o
);
    import ddr_modeload_pkg::*;

    logic need_rst;

    // Remember that a DLL-enabling extended load still awaits its reset load.
    always_ff @(posedge clk) begin
        if (!rst_n)
            need_rst <= 1'b0;
        else if (cmd_o == CMD_LMR && ba_o == BA_EXT && !addr_o[EXT_DLL_BIT])
            need_rst <= 1'b1;
        else if (cmd_o != CMD_NOP)
            need_rst <= 1'b0;
    end

    p_ba_select_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_o == CMD_LMR |-> (ba_o == BA_EXT || ba_o == BA_BASE));

    p_refused_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (!busy_o && cmd_o != CMD_LMR));

    p_load_when_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_o == CMD_LMR |-> $past(banks_idle && !burst_active));

    p_settle_nop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_o == CMD_LMR |=> (cmd_o == CMD_NOP && busy_o));

    p_dll_reset_next_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (need_rst && cmd_o != CMD_NOP) |->
            (cmd_o == CMD_LMR && ba_o == BA_BASE && addr_o[DLL_RST_BIT]));

    p_read_after_lock_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_o == CMD_READ |-> $past(rd_ok_o));

    p_srexit_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sr_exit |=> !rd_ok_o);

endmodule

bind ddr_modeload_seq ddr_modeload_seq_chk #(.AW(AW)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .banks_idle   (banks_idle),
    .burst_active (burst_active),
    .sr_exit      (sr_exit),
    .cmd_o        (cmd_o),
    .ba_o         (ba_o),
    .addr_o       (addr_o),
    .busy_o       (busy_o),
    .rd_ok_o      (rd_ok_o),
    .err_o        (err_o)
);

// File: tb/ddr_modeload_seq_tb_top.sv
// Scoreboard bench: driver tasks queue expected commands, a monitor pops
// and compares every non-NOP command and checks gaps and lock timing.
module ddr_modeload_seq_tb_top;
    import ddr_modeload_pkg::*;

    localparam int AW     = 13;
    localparam int SETTLE = 2;
    localparam int LOCK   = 200;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cfg_valid, cfg_ext;
    logic [AW-1:0] cfg_value;
    logic          banks_idle, burst_active, rd_req, sr_exit;
    logic [1:0]    cmd_o, ba_o;
    logic [AW-1:0] addr_o;
    logic          busy_o, rd_ok_o, err_o;

    always #2 clk = ~clk;

    ddr_modeload_seq #(
        .AW (AW), .SETTLE_CYC (SETTLE), .LOCK_CYC (LOCK)
    ) dut_i (
        .clk (clk), .rst_n (rst_n), .cfg_valid (cfg_valid), .cfg_ext (cfg_ext),
        .cfg_value (cfg_value), .banks_idle (banks_idle),
        .burst_active (burst_active), .rd_req (rd_req), .sr_exit (sr_exit),
        .cmd_o (cmd_o), .ba_o (ba_o), .addr_o (addr_o), .busy_o (busy_o),
        .rd_ok_o (rd_ok_o), .err_o (err_o)
    );

    typedef struct {
        logic [1:0]    cmd;
        logic [1:0]    ba;
        logic [AW-1:0] addr;
        string         tag;
    } exp_t;

    exp_t          sbq[$];
    int            n_chk = 0;
    int            n_fail = 0;
    int            cyc = 0;
    int            t_en = 0;
    string         lock_tag = "R8";
    logic          prev_rdok = 1'b0;
    bit            after_lmr = 1'b0;
    int            nop_run = 0;
    logic [AW-1:0] shadow_m = '0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic void push(input logic [1:0] c, input logic [1:0] b,
                                 input logic [AW-1:0] a, input string t);
        exp_t e;
        e.cmd = c; e.ba = b; e.addr = a; e.tag = t;
        sbq.push_back(e);
    endfunction

    // Monitor: sample just after each edge, compare with the scoreboard.
    always begin
        @(posedge clk);
        #1;
        cyc++;
        if (rst_n) begin
            if (cmd_o != CMD_NOP) begin
                if (after_lmr) chk(nop_run >= SETTLE, "R5", "nop gap", nop_run, SETTLE);
                if (cmd_o == CMD_READ) chk(prev_rdok, "R8", "rd_ok before READ", prev_rdok, 1);
                if (cmd_o == CMD_LMR)
                    chk(banks_idle && !burst_active, "R4", "idle at load",
                        {banks_idle, burst_active}, 2'b10);
                if (sbq.size() == 0) begin
                    chk(0, "R11", "unexpected command", {cmd_o, ba_o, addr_o}, 0);
                end else begin
                    exp_t e;
                    e = sbq.pop_front();
                    chk(cmd_o == e.cmd && ba_o == e.ba && addr_o == e.addr, e.tag,
                        "command", {cmd_o, ba_o, addr_o}, {e.cmd, e.ba, e.addr});
                end
                if (cmd_o == CMD_LMR) begin
                    after_lmr = 1'b1;
                    nop_run   = 0;
                    if (ba_o == BA_EXT && !addr_o[0]) begin
                        t_en = cyc;
                        lock_tag = "R8";
                    end
                end else begin
                    after_lmr = 1'b0;
                end
            end else if (after_lmr) begin
                nop_run++;
                if (nop_run < SETTLE) chk(busy_o, "R5", "busy in settle", busy_o, 1);
            end
            if (sr_exit) begin
                t_en = cyc;
                lock_tag = "R9";
                chk(!rd_ok_o, "R9", "rd_ok after sr_exit", rd_ok_o, 0);
            end
            if (rd_ok_o && !prev_rdok)
                chk(cyc - t_en == LOCK, lock_tag, "lock window", cyc - t_en, LOCK);
            prev_rdok = rd_ok_o;
        end
    end

    task automatic cfg(input bit ext, input logic [AW-1:0] val, input bit ok);
        @(negedge clk);
        while (busy_o) @(negedge clk);
        cfg_valid = 1'b1; cfg_ext = ext; cfg_value = val;
        if (ok) begin
            push(CMD_LMR, ext ? BA_EXT : BA_BASE, val, "R2");
            if (!ext) shadow_m = val;
            if (ext && !val[0]) push(CMD_LMR, BA_BASE, shadow_m | 13'h100, "R6");
        end
        @(negedge clk);
        cfg_valid = 1'b0;
        if (!ok) begin
            chk(err_o, "R3", "err_o", err_o, 1);
            chk(!busy_o, "R3", "busy_o", busy_o, 0);
        end
    endtask

    task automatic wait_quiet();
        do @(negedge clk); while (sbq.size() != 0 || busy_o);
    endtask

    task automatic rd_pulse(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rd_req = 1'b1;
        end
        @(negedge clk);
        rd_req = 1'b0;
    endtask

    task automatic sr_pulse();
        @(negedge clk);
        sr_exit = 1'b1;
        @(negedge clk);
        sr_exit = 1'b0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failure.
    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=done", cyc);
        finish_run();
    end

    // Driver: stimulus sequence.
    initial begin
        rst_n = 1'b0; cfg_valid = 1'b0; cfg_ext = 1'b0; cfg_value = '0;
        banks_idle = 1'b1; burst_active = 1'b0; rd_req = 1'b0; sr_exit = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(cmd_o == CMD_NOP, "R1", "cmd_o", cmd_o, 0);
        chk(!busy_o, "R1", "busy_o", busy_o, 0);
        chk(!rd_ok_o, "R1", "rd_ok_o", rd_ok_o, 0);
        chk(!err_o, "R1", "err_o", err_o, 0);

        // R2: plain base load
        cfg(1'b0, 13'h062, 1'b1);
        wait_quiet();

        // R3: refused extended values
        cfg(1'b1, 13'h004, 1'b0);
        cfg(1'b1, 13'h002, 1'b0);
        cfg(1'b1, 13'h1000, 1'b0);
        repeat (5) @(negedge clk);

        // R11: reads held while DLL is off
        rd_pulse(3);
        repeat (5) @(negedge clk);
        chk(!rd_ok_o, "R11", "rd_ok_o while off", rd_ok_o, 0);

        // R4: DLL enable waits for banks idle and no burst; R6 chained reset
        banks_idle = 1'b0;
        cfg(1'b1, 13'h000, 1'b1);
        for (int i = 0; i < 3; i++) push(CMD_READ, 2'b00, '0, "R11");
        repeat (6) begin
            @(negedge clk);
            chk(busy_o && cmd_o == CMD_NOP, "R4", "waiting banks", {busy_o, cmd_o}, 3'b100);
        end
        banks_idle = 1'b1;
        burst_active = 1'b1;
        repeat (4) begin
            @(negedge clk);
            chk(busy_o && cmd_o == CMD_NOP, "R4", "waiting burst", {busy_o, cmd_o}, 3'b100);
        end
        burst_active = 1'b0;
        wait_quiet();

        // R9: self-refresh exit restarts the lock window
        sr_pulse();
        rd_pulse(2);
        push(CMD_READ, 2'b00, '0, "R9");
        push(CMD_READ, 2'b00, '0, "R9");
        wait_quiet();

        // R10: DLL off clears rd_ok and holds reads
        cfg(1'b1, 13'h001, 1'b1);
        wait_quiet();
        chk(!rd_ok_o, "R10", "rd_ok_o after disable", rd_ok_o, 0);
        rd_pulse(2);
        repeat (30) @(negedge clk);
        chk(!rd_ok_o, "R10", "rd_ok_o still low", rd_ok_o, 0);
        push(CMD_READ, 2'b00, '0, "R10");
        push(CMD_READ, 2'b00, '0, "R10");
        sr_pulse();
        wait_quiet();

        // R12: read grant and request acceptance in the same cycle
        @(negedge clk);
        rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
        cfg_valid = 1'b1; cfg_ext = 1'b0; cfg_value = 13'h031;
        push(CMD_READ, 2'b00, '0, "R12");
        push(CMD_LMR, BA_BASE, 13'h031, "R12");
        shadow_m = 13'h031;
        @(negedge clk);
        cfg_valid = 1'b0;
        chk(cmd_o == CMD_READ && busy_o, "R12", "read with busy", {cmd_o, busy_o}, 3'b101);
        wait_quiet();

        // R7: chained load uses the newest base value
        cfg(1'b1, 13'h000, 1'b1);
        sbq[sbq.size()-1].tag = "R7";
        wait_quiet();
        repeat (LOCK + 4) @(negedge clk);
        chk(rd_ok_o, "R8", "rd_ok_o after lock", rd_ok_o, 1);
        chk(sbq.size() == 0, "R11", "scoreboard empty", sbq.size(), 0);
        finish_run();
    end

endmodule